// File: doc/BRIEF.md
# Downstream Port Power and Indicator Controller

This block drives the power switches and the two-colour status lights of a hub's downstream ports. It filters each port's active-low over-current pin, removes power from a port (or from the whole group) once a fault has persisted, and reports a per-port over-current status bit with a sticky change bit for the hub's register logic. Power requests, port-enabled flags, error flags and indicator selectors come from that register logic. The number of ports in use, the switch polarity and the grouping mode come from configuration straps.

In grouped mode, one over-current pin and one enable pin serve every port. The enable outputs can be strapped as active-high or active-low. Each port's light follows a two-bit selector: automatic, forced amber, forced green or forced off. All lights go dark while the hub is globally suspended. The amber outputs stay low while the configuration memory is present, because those pins also serve that memory.

Top module: `dsport_pwr_led`

## Requirements
- R1: An over-current input must stay low for DEB_CYC consecutive clock cycles, plus a two-stage input synchroniser, before it is acted on. A low pulse shorter than that leaves the status, change and power outputs unchanged.
- R2: A recognised over-current clears that port's status-visible power and sets its status bit. Power stays off after the fault clears. It returns only after the port's power request is withdrawn for at least one cycle and then reasserted.
- R3: A change bit is set whenever its port's status bit changes in either direction. It stays set until a one-cycle clear strobe is given on that port's bit of the clear input.
- R4: With the polarity input at 1, an enable pin is 1 when its port is powered. With the polarity input at 0, the pin is 0 when the port is powered. An unpowered or unused pin sits at the inactive level.
- R5: In grouped mode, only over-current input bit 0 is observed, and it sets the status of every active port. The group is powered when any active port requests power. Only enable pin 0 is driven, and the other pins stay inactive.
- R6: The indicator selector for port i sits in bits [2i+1:2i]. Its codes are 0 = automatic, 1 = amber, 2 = green and 3 = off.
- R7: In automatic mode, a port shows amber when its over-current status or its error flag is set. Otherwise it shows green when it is powered and enabled, and it is dark in all other cases. At most one colour is lit per port.
- R8: While the suspend input is 1, every green and amber output is 0.
- R9: While the memory-present input is 1, every amber output is 0, whatever the selector.
- R10: A port whose index (0-based) is not below the active port count is never powered, its lights are dark, and its over-current input has no effect on its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_n_i | input | NPORT | Over-current pins, active low |
| gang_mode_i | input | 1 | 1 = grouped power and over-current |
| pwr_pol_hi_i | input | 1 | 1 = enable pins active-high |
| port_cnt_i | input | $clog2(NPORT+1) | Number of active ports |
| pwr_req_i | input | NPORT | Port power requests |
| port_en_i | input | NPORT | Port enabled flags |
| port_err_i | input | NPORT | Port error flags |
| ind_sel_i | input | 2*NPORT | Indicator selectors, two bits per port |
| suspend_i | input | 1 | Global suspend |
| eeprom_present_i | input | 1 | Configuration memory present |
| oc_clr_i | input | NPORT | One-cycle change-bit clear strobes |
| pwr_en_o | output | NPORT | Power switch enable pins |
| led_green_o | output | NPORT | Green indicator pins |
| led_amber_o | output | NPORT | Amber indicator pins |
| oc_status_o | output | NPORT | Over-current status per port |
| oc_change_o | output | NPORT | Over-current change per port |

## Verification
The bench builds the block with four ports and DEB_CYC set to 5, instead of the default of several tens of thousands of cycles. This makes both a sub-threshold glitch and a full over-current trip fit in a few cycles, and the trip can be repeated in individual mode, grouped mode and on a port beyond the active count. With four ports, the bench can also cover the active-count masking at a count of 2 and the mapping of the two-bit selector fields.

// File: rtl/dpl_pkg.sv
// Shared types for the downstream port power and indicator controller.
package dpl_pkg;
    typedef enum logic [1:0] {
        IND_AUTO  = 2'd0,
        IND_AMBER = 2'd1,
        IND_GREEN = 2'd2,
        IND_OFF   = 2'd3
    } ind_mode_e;
endpackage

// File: rtl/dpl_oc_filter.sv
// Over-current filter for one port: synchronises the active-low pin and
// reports a fault once it has been low for DEB_CYC consecutive cycles.
// Assumes the pin is asynchronous to clk; release is recognised at once.
module dpl_oc_filter #(
    parameter int DEB_CYC = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n_i,
    output logic oc_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-stage synchroniser and saturating low-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], oc_n_i};
            if (sync_q[1])
                cnt_q <= '0;
            else if (cnt_q != CW'(DEB_CYC))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign oc_o = (cnt_q == CW'(DEB_CYC));

    // R1
    flt_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_o) |-> !$past(sync_q[1]));
endmodule

// File: rtl/dpl_pwr_ctrl.sv
// Power and over-current state for all ports: per-port trip latches,
// status and sticky change bits, grouped-mode merging and active masking.
// Assumes filtered over-current inputs; pins are formed by the parent.
module dpl_pwr_ctrl #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] oc_flt_i,
    input  logic             gang_i,
    input  logic [NPORT-1:0] active_i,
    input  logic [NPORT-1:0] pwr_req_i,
    input  logic [NPORT-1:0] oc_clr_i,
    output logic [NPORT-1:0] pwr_on_o,
    output logic [NPORT-1:0] pin_on_o,
    output logic [NPORT-1:0] oc_status_o,
    output logic [NPORT-1:0] oc_change_o
);
    logic [NPORT-1:0] eff_oc, req_eff, trip_q, status_q, change_q;
    logic             grp_req, grp_on;

    assign grp_req = |(pwr_req_i & active_i);
    assign grp_on  = |pwr_on_o;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        // Fault and request seen by this port, per grouping mode.
        always_comb begin
            eff_oc[i]  = active_i[i] & (gang_i ? oc_flt_i[0] : oc_flt_i[i]);
            req_eff[i] = gang_i ? grp_req : pwr_req_i[i];
        end

        // Trip latch, status and sticky change bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trip_q[i]   <= 1'b0;
                status_q[i] <= 1'b0;
                change_q[i] <= 1'b0;
            end else begin
                if (eff_oc[i])
                    trip_q[i] <= 1'b1;
                else if (!req_eff[i])
                    trip_q[i] <= 1'b0;
                status_q[i] <= eff_oc[i];
                change_q[i] <= (eff_oc[i] != status_q[i]) |
                               (change_q[i] & ~oc_clr_i[i]);
            end
        end

        // Logical power state and the pin it lands on.
        always_comb begin
            pwr_on_o[i] = active_i[i] & req_eff[i] & ~trip_q[i];
            if (gang_i)
                pin_on_o[i] = (i == 0) ? grp_on : 1'b0;
            else
                pin_on_o[i] = pwr_on_o[i];
        end

        // R2
        trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> !pwr_on_o[i]);
        // R3
        chg_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> change_q[i]);
        // R10
        inactive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !active_i[i] |-> !pin_on_o[i] || gang_i);
    end

    assign oc_status_o = status_q;
    assign oc_change_o = change_q;
endmodule

// File: rtl/dpl_led_drv.sv
// Indicator driver: resolves each port's two-bit selector into green and
// amber pins, with suspend blanking, amber suppression and active masking.
// Assumes the power and status inputs come from dpl_pwr_ctrl.
module dpl_led_drv
    import dpl_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NPORT-1:0] ind_sel_i,
    input  logic [NPORT-1:0]   pwr_on_i,
    input  logic [NPORT-1:0]   port_en_i,
    input  logic [NPORT-1:0]   port_err_i,
    input  logic [NPORT-1:0]   oc_status_i,
    input  logic [NPORT-1:0]   active_i,
    input  logic               suspend_i,
    input  logic               eeprom_present_i,
    output logic [NPORT-1:0]   green_o,
    output logic [NPORT-1:0]   amber_o
);
    for (genvar i = 0; i < NPORT; i++) begin : g_led
        ind_mode_e mode;
        logic      g_raw, a_raw;

        assign mode = ind_mode_e'(ind_sel_i[2*i +: 2]);

        // Colour chosen by the selector before gating.
        always_comb begin
            g_raw = 1'b0;
            a_raw = 1'b0;
            unique case (mode)
                IND_AUTO: begin
                    a_raw = oc_status_i[i] | port_err_i[i];
                    g_raw = ~a_raw & pwr_on_i[i] & port_en_i[i];
                end
                IND_AMBER: a_raw = 1'b1;
                IND_GREEN: g_raw = 1'b1;
                IND_OFF:   ;
            endcase
        end

        // Gating by suspend, active count and memory presence.
        always_comb begin
            green_o[i] = g_raw & active_i[i] & ~suspend_i;
            amber_o[i] = a_raw & active_i[i] & ~suspend_i & ~eeprom_present_i;
        end

        // R7
        one_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(green_o[i] && amber_o[i]));
    end

    // R8
    suspend_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |-> (green_o == '0) && (amber_o == '0));
    // R9
    amber_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eeprom_present_i |-> (amber_o == '0));
endmodule

// File: rtl/dsport_pwr_led.sv
// Downstream port power and indicator controller top: per-port over-current
// filters, power/status state, indicator drivers and pin polarity.
// Assumes configuration straps are static while ports are powered.
module dsport_pwr_led #(
    parameter int NPORT   = 4,
    parameter int DEB_CYC = 96000,
    localparam int CNTW   = $clog2(NPORT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]   oc_n_i,
    input  logic               gang_mode_i,
    input  logic               pwr_pol_hi_i,
    input  logic [CNTW-1:0]    port_cnt_i,
    input  logic [NPORT-1:0]   pwr_req_i,
    input  logic [NPORT-1:0]   port_en_i,
    input  logic [NPORT-1:0]   port_err_i,
    input  logic [2*NPORT-1:0] ind_sel_i,
    input  logic               suspend_i,
    input  logic               eeprom_present_i,
    input  logic [NPORT-1:0]   oc_clr_i,
    output logic [NPORT-1:0]   pwr_en_o,
    output logic [NPORT-1:0]   led_green_o,
    output logic [NPORT-1:0]   led_amber_o,
    output logic [NPORT-1:0]   oc_status_o,
    output logic [NPORT-1:0]   oc_change_o
);
    logic [NPORT-1:0] oc_flt, active, pwr_on, pin_on;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        // Port is in use when its index is below the active count.
        assign active[i] = (port_cnt_i > CNTW'(i));

        dpl_oc_filter #(.DEB_CYC(DEB_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .oc_n_i (oc_n_i[i]),
            .oc_o   (oc_flt[i])
        );
    end

    dpl_pwr_ctrl #(.NPORT(NPORT)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .oc_flt_i    (oc_flt),
        .gang_i      (gang_mode_i),
        .active_i    (active),
        .pwr_req_i   (pwr_req_i),
        .oc_clr_i    (oc_clr_i),
        .pwr_on_o    (pwr_on),
        .pin_on_o    (pin_on),
        .oc_status_o (oc_status_o),
        .oc_change_o (oc_change_o)
    );

    dpl_led_drv #(.NPORT(NPORT)) u_led (
        .clk              (clk),
        .rst_n            (rst_n),
        .ind_sel_i        (ind_sel_i),
        .pwr_on_i         (pwr_on),
        .port_en_i        (port_en_i),
        .port_err_i       (port_err_i),
        .oc_status_i      (oc_status_o),
        .active_i         (active),
        .suspend_i        (suspend_i),
        .eeprom_present_i (eeprom_present_i),
        .green_o          (led_green_o),
        .amber_o          (led_amber_o)
    );

    // Apply the strapped switch polarity to every enable pin.
    always_comb begin
        for (int i = 0; i < NPORT; i++)
            pwr_en_o[i] = pwr_pol_hi_i ? pin_on[i] : ~pin_on[i];
    end

    // R5
    gang_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode_i |-> (pwr_en_o[NPORT-1:1] == {(NPORT-1){~pwr_pol_hi_i}}));
    // R10
    inactive_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(port_cnt_i) && !active[NPORT-1] |=> !oc_status_o[NPORT-1]);
endmodule

// File: tb/dsport_pwr_led_tb.sv
module dsport_pwr_led_tb;
    localparam int NPORT = 4;
    localparam int DEB   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       oc_n = 4'hF;
    logic             gang = 1'b0;
    logic             pol = 1'b0;
    logic [2:0]       pcnt = 3'd4;
    logic [3:0]       req = '0, pen = '0, perr = '0, clr = '0;
    logic [7:0]       sel = '0;
    logic             susp = 1'b0, mem = 1'b0;
    logic [3:0]       pwr_en, grn, amb, st, chg;
    int               n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    dsport_pwr_led #(.NPORT(NPORT), .DEB_CYC(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .oc_n_i(oc_n), .gang_mode_i(gang),
        .pwr_pol_hi_i(pol), .port_cnt_i(pcnt), .pwr_req_i(req),
        .port_en_i(pen), .port_err_i(perr), .ind_sel_i(sel),
        .suspend_i(susp), .eeprom_present_i(mem), .oc_clr_i(clr),
        .pwr_en_o(pwr_en), .led_green_o(grn), .led_amber_o(amb),
        .oc_status_o(st), .oc_change_o(chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R4 reset pins", 32'(pwr_en), 32'hF);
        chk("R8 reset leds", 32'({grn, amb}), 32'h0);
        chk("R3 reset status/change", 32'({st, chg}), 32'h0);
    endtask

    task automatic t_polarity;
        req = 4'hF; cyc(1);
        chk("R4 active-low on", 32'(pwr_en), 32'h0);
        pol = 1'b1; cyc(1);
        chk("R4 active-high on", 32'(pwr_en), 32'hF);
        req = 4'b0101; cyc(1);
        chk("R4 active-high mixed", 32'(pwr_en), 32'h5);
        req = 4'hF; cyc(1);
    endtask

    task automatic t_trip;
        oc_n[2] = 1'b0; cyc(3); oc_n[2] = 1'b1; cyc(10);
        chk("R1 glitch status", 32'({st, chg}), 32'h0);
        chk("R1 glitch power", 32'(pwr_en), 32'hF);
        oc_n[2] = 1'b0; cyc(DEB - 1);
        chk("R1 below threshold", 32'(st), 32'h0);
        cyc(6);
        chk("R2 status set", 32'(st), 32'h4);
        chk("R3 change set", 32'(chg), 32'h4);
        chk("R2 power removed", 32'(pwr_en), 32'hB);
        oc_n[2] = 1'b1; cyc(6);
        chk("R2 status cleared", 32'(st), 32'h0);
        chk("R2 power stays off", 32'(pwr_en), 32'hB);
        chk("R3 change on fall", 32'(chg), 32'h4);
        req[2] = 1'b0; cyc(1); req[2] = 1'b1; cyc(1);
        chk("R2 power restored", 32'(pwr_en), 32'hF);
        clr = 4'h4; cyc(1); clr = 4'h0; cyc(1);
        chk("R3 change cleared", 32'(chg), 32'h0);
    endtask

    task automatic t_leds;
        pen = 4'hF; sel = 8'h00; cyc(1);
        chk("R7 auto green", 32'({grn, amb}), 32'hF0);
        pen[1] = 1'b0; cyc(1);
        chk("R7 auto disabled dark", 32'({grn, amb}), 32'hD0);
        perr[3] = 1'b1; cyc(1);
        chk("R7 auto error amber", 32'({grn, amb}), 32'h58);
        sel = {2'd0, 2'd3, 2'd2, 2'd1}; cyc(1);
        chk("R6 manual codes", 32'({grn, amb}), 32'h29);
        mem = 1'b1; cyc(1);
        chk("R9 amber suppressed", 32'({grn, amb}), 32'h20);
        mem = 1'b0; susp = 1'b1; cyc(1);
        chk("R8 suspend dark", 32'({grn, amb}), 32'h00);
        susp = 1'b0; perr = '0; sel = '0; cyc(1);
    endtask

    task automatic t_count;
        pcnt = 3'd2; sel = {4{2'd2}}; cyc(1);
        chk("R10 pins masked", 32'(pwr_en), 32'h3);
        chk("R10 leds masked", 32'({grn, amb}), 32'h30);
        oc_n[3] = 1'b0; cyc(DEB + 6);
        chk("R10 oc ignored", 32'({st, chg}), 32'h0);
        oc_n[3] = 1'b1; pcnt = 3'd4; sel = '0; cyc(4);
    endtask

    task automatic t_gang;
        gang = 1'b1; req = 4'b0100; cyc(1);
        chk("R5 group on pin0", 32'(pwr_en), 32'h1);
        oc_n[1] = 1'b0; cyc(DEB + 6);
        chk("R5 other oc ignored", 32'({st, pwr_en}), 32'h01);
        oc_n[1] = 1'b1; oc_n[0] = 1'b0; cyc(DEB + 6);
        chk("R5 group status", 32'(st), 32'hF);
        chk("R5 group change", 32'(chg), 32'hF);
        chk("R5 group power off", 32'(pwr_en), 32'h0);
        oc_n[0] = 1'b1; req = '0; clr = 4'hF; cyc(5); clr = '0;
        req = 4'b0001; cyc(1);
        chk("R5 group restored", 32'(pwr_en), 32'h1);
        gang = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_polarity();
        t_trip();
        t_leds();
        t_count();
        t_gang();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule